// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Stage

This block sits in the transmit path of a 32-bit Ethernet MAC, between the frame source and the line encoder. Frames arrive as a stream of 32-bit words. The first word carries a start flag. The last word carries an end flag and a count of the bytes in it that are valid. A frame shorter than the minimum size is extended with zero bytes. The CRC-32 frame check sequence is then appended right after the last payload or pad byte. The result leaves on a 32-bit output that uses the same start, end and byte-count signalling.

The stage is pipelined. An input register cleans the final word. A body register folds each word into the running CRC. An output register merges the leading FCS bytes into the final body word. The byte count of the final word travels alongside the data through every one of these registers. While pad words are generated, and for one cycle after each frame so the FCS tail can drain, the block holds off its source through a ready signal.

Byte order on both buses is little-endian by lane: the first byte of a word sits in bits 7:0 and the fourth in bits 31:24. The minimum frame size, FCS included, is a parameter whose default is 64 bytes.

Top module: `eth_tx_pad_fcs`

## Requirements
- R1: Output byte lane i sits in bits 8i+7:8i, and the earliest byte is in lane 0. Every output word without the end flag carries 4 bytes and shows outBytes = 4. The word with outEnd high carries the last FCS byte, and outBytes gives its byte count, encoded 1 to 4 as the values 3'd1 to 3'd4.
- R2: On an input word with inEnd high, lanes at or above inBytes are ignored. Whatever they hold has no effect on the output bytes or on the FCS.
- R3: A frame with fewer than 60 payload bytes is extended with pad bytes up to exactly 60 bytes before the FCS. A 42-byte frame therefore receives 18 pad bytes and leaves as 64 bytes.
- R4: Every pad byte is 0x00, whatever value inData holds while padding is under way.
- R5: A frame of 60 payload bytes or more gets no padding. The output is its payload followed directly by 4 FCS bytes.
- R6: The FCS is CRC-32 over payload and pad bytes: reflected polynomial 0xEDB88320, seed 0xFFFFFFFF, result inverted, sent least significant byte first.
- R7: The FCS starts at the byte right after the last payload or pad byte. When the padded length is not a multiple of 4, the FCS spans two output words, and the end word carries as many bytes as the padded length modulo 4.
- R8: After accepting the end word of a frame, inReady is held low for one cycle per generated pad word plus one further cycle before the next word is taken.
- R9: outStart is high on exactly the first output word of every frame.
- R10: While reset is applied and right after it, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Stage accepts the input word on this edge |
| inData | input | 32 | Input frame bytes, lane 0 first |
| inStart | input | 1 | First word of a frame |
| inEnd | input | 1 | Last word of a frame |
| inBytes | input | 3 | Valid bytes in the end word, 1 to 4 |
| outValid | output | 1 | Output word present |
| outData | output | 32 | Output frame bytes, lane 0 first |
| outStart | output | 1 | First output word of a frame |
| outEnd | output | 1 | Output word holding the last FCS byte |
| outBytes | output | 3 | Valid bytes in the output word, 4 unless at the end |

## Verification
The bench builds the block with its default minimum frame of 64 bytes, so the padded body is 15 words. This brings three regions into reach with short frames: frames that need separate pad words (1 and 42 bytes), frames whose final word is itself the fifteenth word and only needs its own empty lanes zeroed (57 to 59 bytes), and frames just past the limit whose FCS splits across two words (61 to 63 bytes). Back-to-back frames with the next word already waiting measure the exact stall length in both the padded and the unpadded case.

// File: rtl/eth_txfcs_pkg.sv
package eth_txfcs_pkg;

  localparam logic [31:0] CrcPolyRefl = 32'hEDB88320;
  localparam logic [31:0] CrcSeed     = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PAD,
    ST_GAP
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       takeIn;     // input register hands its word on
    logic       loadBody;   // body register loads a word
    logic       padWord;    // that word is zero padding
    logic       lastWord;   // that word is the final body word
    logic [2:0] lastBytes;  // live bytes in the final body word
    logic [2:0] crcBytes;   // bytes folded into the CRC this cycle
    logic       clearCrc;   // frame finished, reseed CRC
  } ctrlStb_t;

  // Fold up to four bytes (lane 0 first) into a reflected CRC-32
  function automatic logic [31:0] crcAdvance(input logic [31:0] crcIn,
                                             input logic [31:0] word,
                                             input logic [2:0]  nBytes);
    logic [31:0] c;
    c = crcIn;
    for (int b = 0; b < 4; b++) begin
      if (3'(b) < nBytes) begin
        c = c ^ {24'h0, word[8*b +: 8]};
        for (int k = 0; k < 8; k++) begin
          c = c[0] ? ((c >> 1) ^ CrcPolyRefl) : (c >> 1);
        end
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_txfcs_ctrl.sv
module eth_txfcs_ctrl
  import eth_txfcs_pkg::*;
#(
  parameter int MinFrameBytes = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aValid,
  input  logic       aEnd,
  input  logic [2:0] aBytes,
  output ctrlStb_t   stb
);

  localparam int BodyWords = (MinFrameBytes - 4) / 4;
  localparam int LastIdx   = BodyWords - 1;
  localparam int CntW      = $clog2(BodyWords + 1);

  ctrlState_t      state, stateNxt;
  logic [CntW-1:0] wordCnt;
  logic            belowLast, atLast;

  assign belowLast = wordCnt < CntW'(LastIdx);
  assign atLast    = wordCnt == CntW'(LastIdx);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (aValid) begin
          stb.takeIn   = 1'b1;
          stb.loadBody = 1'b1;
          stb.crcBytes = 3'd4;
          if (aEnd) begin
            if (belowLast) begin
              // more zero words follow; empty lanes already cleared
              stateNxt = ST_PAD;
            end else if (atLast && aBytes != 3'd4) begin
              stb.lastWord  = 1'b1;
              stb.lastBytes = 3'd4;
              stateNxt      = ST_GAP;
            end else begin
              stb.lastWord  = 1'b1;
              stb.lastBytes = aBytes;
              stb.crcBytes  = aBytes;
              stateNxt      = ST_GAP;
            end
          end
        end
      end
      ST_PAD: begin
        stb.loadBody = 1'b1;
        stb.padWord  = 1'b1;
        stb.crcBytes = 3'd4;
        if (atLast) begin
          stb.lastWord  = 1'b1;
          stb.lastBytes = 3'd4;
          stateNxt      = ST_GAP;
        end
      end
      ST_GAP: begin
        stb.clearCrc = 1'b1;
        stateNxt     = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wordCnt <= '0;
    end else begin
      state <= stateNxt;
      if (stb.clearCrc) begin
        wordCnt <= '0;
      end else if (stb.loadBody && wordCnt != CntW'(BodyWords)) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eth_txfcs_dp.sv
module eth_txfcs_dp
  import eth_txfcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        inStart,
  input  logic        inEnd,
  input  logic [2:0]  inBytes,
  input  ctrlStb_t    stb,
  output logic        aValid,
  output logic        aEnd,
  output logic [2:0]  aBytes,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        outStart,
  output logic        outEnd,
  output logic [2:0]  outBytes
);

  // input register
  logic [31:0] aData;
  logic        aStart;
  logic [31:0] inMasked;

  // body register and running CRC
  logic        bValid, bStart, bLast;
  logic [31:0] bData;
  logic [2:0]  bBytes;
  logic [31:0] crcReg;
  logic [31:0] bodyIn;

  // FCS tail held for the second output word
  logic        tailPending;
  logic [31:0] fcsHold;
  logic [2:0]  tailBytes;

  logic [31:0] fcsNow;
  logic [31:0] mergedWord;
  logic [31:0] tailWord;

  assign inReady = !aValid || stb.takeIn;
  assign bodyIn  = stb.padWord ? 32'h0 : aData;
  assign fcsNow  = ~crcReg;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      inMasked[8*i +: 8] = (inEnd && 3'(i) >= inBytes) ? 8'h00 : inData[8*i +: 8];
    end
  end

  always_comb begin
    logic [4:0]  sh;
    logic [31:0] tmp;
    for (int i = 0; i < 4; i++) begin
      sh  = 5'({2'(i), 3'b000}) - 5'({bBytes[1:0], 3'b000});
      tmp = fcsNow >> sh;
      mergedWord[8*i +: 8] = (3'(i) < bBytes) ? bData[8*i +: 8] : tmp[7:0];
    end
  end

  always_comb begin
    logic [5:0]  off;
    logic [31:0] tmp;
    for (int i = 0; i < 4; i++) begin
      off = 6'({2'(i), 3'b000}) + 6'd32 - 6'({tailBytes, 3'b000});
      tmp = fcsHold >> off;
      tailWord[8*i +: 8] = (3'(i) < tailBytes) ? tmp[7:0] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      aData  <= '0;
      aStart <= 1'b0;
      aEnd   <= 1'b0;
      aBytes <= 3'd4;
    end else if (inReady) begin
      aValid <= inValid;
      if (inValid) begin
        aData  <= inMasked;
        aStart <= inStart;
        aEnd   <= inEnd;
        aBytes <= inEnd ? inBytes : 3'd4;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
      bData  <= '0;
      bStart <= 1'b0;
      bLast  <= 1'b0;
      bBytes <= 3'd4;
      crcReg <= CrcSeed;
    end else begin
      bValid <= stb.loadBody;
      if (stb.loadBody) begin
        bData  <= bodyIn;
        bStart <= !stb.padWord && aStart;
        bLast  <= stb.lastWord;
        bBytes <= stb.lastBytes;
      end
      if (stb.clearCrc) begin
        crcReg <= CrcSeed;
      end else if (stb.loadBody) begin
        crcReg <= crcAdvance(crcReg, bodyIn, stb.crcBytes);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      outStart    <= 1'b0;
      outEnd      <= 1'b0;
      outBytes    <= 3'd4;
      tailPending <= 1'b0;
      fcsHold     <= '0;
      tailBytes   <= 3'd4;
    end else if (tailPending) begin
      outValid    <= 1'b1;
      outData     <= tailWord;
      outStart    <= 1'b0;
      outEnd      <= 1'b1;
      outBytes    <= tailBytes;
      tailPending <= 1'b0;
    end else if (bValid) begin
      outValid <= 1'b1;
      outStart <= bStart;
      outEnd   <= 1'b0;
      outBytes <= 3'd4;
      if (bLast) begin
        outData     <= mergedWord;
        fcsHold     <= fcsNow;
        tailBytes   <= bBytes;
        tailPending <= 1'b1;
      end else begin
        outData <= bData;
      end
    end else begin
      outValid <= 1'b0;
      outStart <= 1'b0;
      outEnd   <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_tx_pad_fcs.sv
module eth_tx_pad_fcs
  import eth_txfcs_pkg::*;
#(
  parameter int MinFrameBytes = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        inStart,
  input  logic        inEnd,
  input  logic [2:0]  inBytes,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        outStart,
  output logic        outEnd,
  output logic [2:0]  outBytes
);

  ctrlStb_t   ctrlStb;
  logic       aValid, aEnd;
  logic [2:0] aBytes;

  eth_txfcs_ctrl #(
    .MinFrameBytes(MinFrameBytes)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .aValid (aValid),
    .aEnd   (aEnd),
    .aBytes (aBytes),
    .stb    (ctrlStb)
  );

  eth_txfcs_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .inData   (inData),
    .inStart  (inStart),
    .inEnd    (inEnd),
    .inBytes  (inBytes),
    .stb      (ctrlStb),
    .aValid   (aValid),
    .aEnd     (aEnd),
    .aBytes   (aBytes),
    .outValid (outValid),
    .outData  (outData),
    .outStart (outStart),
    .outEnd   (outEnd),
    .outBytes (outBytes)
  );

endmodule

// File: rtl/eth_tx_pad_fcs_chk.sv
module eth_tx_pad_fcs_chk #(
  parameter int MinFrameBytes = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic       outStart,
  input logic       outEnd,
  input logic [2:0] outBytes
);

  logic        expectStart;
  logic [15:0] byteCnt;
  logic        wasInReset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectStart <= 1'b1;
      byteCnt     <= '0;
      wasInReset  <= 1'b1;
    end else begin
      wasInReset <= 1'b0;
      if (outValid) begin
        expectStart <= outEnd;
        if (outEnd) begin
          byteCnt <= '0;
        end else if (byteCnt < 16'hFFF0) begin
          byteCnt <= byteCnt + 16'd4;
        end
      end
    end
  end

  AST_END_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEnd |-> (outBytes >= 3'd1 && outBytes <= 3'd4)); // R1

  AST_MID_WORD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outEnd |-> outBytes == 3'd4); // R1

  AST_TAIL_FOLLOWS_BODY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEnd |-> $past(outValid) && !$past(outEnd)); // R7

  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEnd |-> (byteCnt + 16'(outBytes)) >= 16'(MinFrameBytes)); // R3

  AST_START_FIRST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && expectStart |-> outStart); // R9

  AST_NO_START_MIDFRAME: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !expectStart |-> !outStart); // R9

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    wasInReset |-> !outValid && inReady); // R10

endmodule

bind eth_tx_pad_fcs eth_tx_pad_fcs_chk #(.MinFrameBytes(MinFrameBytes)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outStart (outStart),
  .outEnd   (outEnd),
  .outBytes (outBytes)
);

// File: tb/test_eth_tx_pad_fcs.sv
module test_eth_tx_pad_fcs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inStart = 1'b0;
  logic        inEnd = 1'b0;
  logic [2:0]  inBytes = 3'd4;
  logic        outValid;
  logic [31:0] outData;
  logic        outStart;
  logic        outEnd;
  logic [2:0]  outBytes;

  int totalCnt = 0;
  int badCnt = 0;
  int cycleCnt = 0;

  logic [7:0] rxQ[$];
  logic [7:0] expQ[$];
  int         endCnt = 0;
  int         startErr = 0;
  int         lastEndBytes = 0;
  logic       monExpectStart = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  eth_tx_pad_fcs i_eth_tx_pad_fcs (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .inData   (inData),
    .inStart  (inStart),
    .inEnd    (inEnd),
    .inBytes  (inBytes),
    .outValid (outValid),
    .outData  (outData),
    .outStart (outStart),
    .outEnd   (outEnd),
    .outBytes (outBytes)
  );

  // Output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      int n;
      n = outEnd ? int'(outBytes) : 4;
      if (n > 4) n = 4;
      for (int k = 0; k < n; k++) rxQ.push_back(outData[8*k +: 8]);
      if (outStart != monExpectStart) startErr++;
      monExpectStart = outEnd;
      if (outEnd) begin
        endCnt++;
        lastEndBytes = int'(outBytes);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    totalCnt++;
    if (!ok) begin
      badCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  // Reference CRC-32, reflected, LSB first
  function automatic logic [31:0] refCrc(input logic [7:0] bytes[$]);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    foreach (bytes[j]) begin
      c ^= {24'h0, bytes[j]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic addExpected(input int len, input int seed);
    logic [7:0] body[$];
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) body.push_back(payByte(seed, i));
    while (body.size() < 60) body.push_back(8'h00);
    fcs = refCrc(body);
    foreach (body[j]) expQ.push_back(body[j]);
    for (int k = 0; k < 4; k++) expQ.push_back(fcs[8*k +: 8]);
  endtask

  // Drive one frame; garbage lanes past the end; returns stall cycles
  task automatic driveFrame(input int len, input int seed, output int stalls);
    int nWords;
    stalls = 0;
    nWords = (len + 3) / 4;
    for (int w = 0; w < nWords; w++) begin
      for (int k = 0; k < 4; k++) begin
        inData[8*k +: 8] = (4*w + k < len) ? payByte(seed, 4*w + k) : 8'hA5;
      end
      inValid = 1'b1;
      inStart = (w == 0);
      inEnd   = (w == nWords - 1);
      inBytes = (w == nWords - 1) ? 3'(len - 4*w) : 3'd4;
      while (!inReady) begin
        stalls++;
        @(negedge clk);
      end
      @(negedge clk);
    end
    inValid = 1'b0;  // inData keeps the last word as bus garbage
  endtask

  task automatic waitEnds(input int target);
    int guard;
    guard = 0;
    while (endCnt < target && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compareOut(input string tag);
    int mism;
    int n;
    mism = 0;
    chk(rxQ.size() == expQ.size(), {tag, " length"}, rxQ.size(), expQ.size());
    n = (rxQ.size() < expQ.size()) ? rxQ.size() : expQ.size();
    for (int i = 0; i < n; i++) if (rxQ[i] !== expQ[i]) mism++;
    chk(mism == 0, {tag, " bytes"}, mism, 0);
    if (n >= 4) begin
      chk({rxQ[n-1], rxQ[n-2], rxQ[n-3], rxQ[n-4]} === {expQ[n-1], expQ[n-2], expQ[n-3], expQ[n-4]},
          {tag, " R6 fcs"}, {rxQ[n-1], rxQ[n-2], rxQ[n-3], rxQ[n-4]},
          {expQ[n-1], expQ[n-2], expQ[n-3], expQ[n-4]});
    end
    rxQ.delete();
    expQ.delete();
  endtask

  function automatic int endBytesFor(input int len);
    int tot;
    tot = ((len < 60) ? 60 : len) + 4;
    return (tot % 4 == 0) ? 4 : tot % 4;
  endfunction

  task automatic testReset();
    // R10: idle and ready while in reset and after release
    chk(outValid == 1'b0, "R10 outValid in reset", outValid, 0);
    chk(inReady == 1'b1, "R10 inReady in reset", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R10 outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R10 inReady after reset", inReady, 1);
  endtask

  task automatic testSingle(input int len, input int seed, input string tag);
    int st;
    int base;
    base = endCnt;
    addExpected(len, seed);
    driveFrame(len, seed, st);
    waitEnds(base + 1);
    compareOut(tag);
    chk(lastEndBytes == endBytesFor(len), {tag, " R1 R7 end bytes"}, lastEndBytes, endBytesFor(len));
  endtask

  task automatic testBackToBack(input int len1, input int len2, input int expStall, input string tag);
    int st1, st2;
    int base;
    base = endCnt;
    addExpected(len1, 3);
    addExpected(len2, 9);
    driveFrame(len1, 3, st1);
    driveFrame(len2, 9, st2);
    waitEnds(base + 2);
    compareOut(tag);
    chk(st2 == expStall, {tag, " R8 stall cycles"}, st2, expStall);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    repeat (2) @(negedge clk);
    testSingle(42, 1, "R3 R4 R2 len42");
    testSingle(1, 2, "R3 len1");
    testSingle(57, 4, "R3 R2 len57");
    testSingle(59, 5, "R3 R7 len59");
    testSingle(60, 6, "R5 len60");
    testSingle(61, 7, "R5 R7 len61");
    testSingle(62, 8, "R7 len62");
    testSingle(63, 10, "R7 len63");
    testSingle(100, 11, "R5 R6 len100");
    // R8: 42 bytes -> 4 pad words + 1; 70 bytes -> 1
    testBackToBack(42, 70, 5, "R8 R4 pad then long");
    testBackToBack(70, 30, 1, "R8 long then short");
    chk(startErr == 0, "R9 start flags", startErr, 0);
    $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      totalCnt++;
      badCnt++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycleCnt);
      $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
      $finish;
    end
  end

endmodule